// File: doc/BRIEF.md
# RMON Frame Statistics Counter Bank

This block keeps the statistics counters for one direction of an Ethernet port. It watches a single-cycle frame-completion event that carries the frame length in bytes and a set of status flags. From each event it updates a frame counter, a wide byte counter, counters for multicast, broadcast and pause frames, a set of error-category counters, and a seven-bucket histogram of frame sizes. The receive and transmit sides use the same module. The `IS_RX` parameter picks the variant. Receive keeps five flag-driven error counters plus a short-frame counter. Transmit keeps a single general error counter, which covers bad FCS and underrun.

Software reads the counters through a simple strobe-and-address read port. The read data is registered and appears one cycle after the strobe. Every read clears the counter it reads. The byte counter is 45 bits wide and is read as two words. Reading the low word clears the whole counter and captures its upper bits in a snapshot register, which the high-word address then returns. A global clear input zeroes every counter and the snapshot.

Top module: `rmon_stats_bank`

## Requirements
- R1: After a synchronous reset, every readable address returns zero.
- R2: Each frame event adds one to the frame counter (address 2). It also adds the event length to the 45-bit byte counter, which is read as bits 31:0 at address 0 and bits 44:32 at address 1.
- R3: The multicast, broadcast and pause counters (addresses 3, 4, 5) each count the events whose matching flag is set.
- R4: On the receive variant, address 6+k counts the events whose `ev_err[k]` is set, for k = 0..4. The bits mean: 0 FCS error, 1 jabber, 2 symbol-code error, 3 oversize, 4 longer than the programmed maximum packet size.
- R5: Addresses 12 to 18 count frames by length in these bins: exactly 64, 65-127, 128-255, 256-511, 512-1023, 1024-1518, and 1519 or more.
- R6: A frame shorter than 64 bytes goes into no size bin. On the receive variant it is counted in the short-frame counter at address 11.
- R7: A read returns the counter's value from the cycle of the strobe, and that counter is zero afterwards.
- R8: If a frame event falls in the same cycle as a read of a counter it updates, the read returns the old value and the counter restarts at that event's increment.
- R9: Reading address 0 captures bits 44:32 of the byte counter. A later read of address 1 returns exactly those bits, so the two words form one snapshot.
- R10: While `clr_all` is high, all counters and the high-word snapshot are set to zero, and a frame event in that cycle is discarded.
- R11: `rd_data` is updated one cycle after `rd_en`. Addresses 19 to 31 read as zero.
- R12: On the transmit variant, only `ev_err[0]` is counted (address 6). Error bits 1 to 4 have no effect, and addresses 7 to 11 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_all | input | 1 | Zero all counters and the snapshot |
| ev_valid | input | 1 | Frame-completion event strobe |
| ev_len | input | LEN_W | Frame length in bytes |
| ev_mcast | input | 1 | Frame is multicast |
| ev_bcast | input | 1 | Frame is broadcast |
| ev_pause | input | 1 | Frame is a pause frame |
| ev_err | input | 5 | Error category flags (see R4) |
| rd_en | input | 1 | Read strobe, clears the addressed counter |
| rd_addr | input | 5 | Counter address |
| rd_data | output | RD_W | Registered read data |

## Verification
On every cycle, the assertions check the frame counter's next-state behaviour: its reset value, increment, clear-on-read, read/event collision and global clear. They also check that at most one size bin is hit per event, that no bin is hit for short frames, and that unmapped reads return zero. Only the bench scenarios can show the counts in the other counters and the exact bin edges. The same holds for the byte counter carrying past 32 bits with a consistent high-word snapshot, and for the transmit variant ignoring the receive-only error flags.

// File: rtl/rmon_pkg.sv
package rmon_pkg;
  localparam int ADDR_W   = 5;
  localparam int NERR     = 5;
  localparam int NBKT     = 7;
  localparam int NREG     = 19;
  localparam int NSLOT    = 2 ** ADDR_W;

  localparam int A_OCT_LO = 0;
  localparam int A_OCT_HI = 1;
  localparam int A_FRAMES = 2;
  localparam int A_MCAST  = 3;
  localparam int A_ERR0   = 6;
  localparam int A_SHORT  = 11;
  localparam int A_BKT0   = 12;

  // Lower bound (inclusive) of each size bin
  function automatic int bkt_lo(input int k);
    case (k)
      0:       return 64;
      1:       return 65;
      2:       return 128;
      3:       return 256;
      4:       return 512;
      5:       return 1024;
      default: return 1519;
    endcase
  endfunction
endpackage

// File: rtl/rmon_ctr.sv
module rmon_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_all,
  input  logic         rd_clr,
  input  logic         inc_en,
  input  logic [W-1:0] inc_amt,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst || clr_all)
      value <= '0;
    else if (rd_clr)
      value <= inc_en ? inc_amt : '0;
    else if (inc_en)
      value <= value + inc_amt;
  end
endmodule

// File: rtl/rmon_bucket_sel.sv
module rmon_bucket_sel #(
  parameter int LEN_W = 16,
  parameter int NBKT  = 7
) (
  input  logic             valid,
  input  logic [LEN_W-1:0] len,
  output logic [NBKT-1:0]  hit
);
  for (genvar k = 0; k < NBKT; k++) begin : g_bin
    localparam logic [LEN_W-1:0] LO = LEN_W'(rmon_pkg::bkt_lo(k));
    if (k < NBKT - 1) begin : g_mid
      localparam logic [LEN_W-1:0] HI = LEN_W'(rmon_pkg::bkt_lo(k + 1));
      assign hit[k] = valid && (len >= LO) && (len < HI);
    end else begin : g_top
      assign hit[k] = valid && (len >= LO);
    end
  end
endmodule

// File: rtl/rmon_stats_bank.sv
module rmon_stats_bank
  import rmon_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int OCT_W     = 45,
  parameter int LEN_W     = 16,
  parameter int RD_W      = 32,
  parameter int SHORT_LEN = 64,
  parameter bit IS_RX     = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_all,
  input  logic              ev_valid,
  input  logic [LEN_W-1:0]  ev_len,
  input  logic              ev_mcast,
  input  logic              ev_bcast,
  input  logic              ev_pause,
  input  logic [NERR-1:0]   ev_err,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [RD_W-1:0]   rd_data
);
  localparam int HI_W = OCT_W - RD_W;

  logic [NSLOT-1:0]  rd_sel;
  logic [OCT_W-1:0]  oct_val;
  logic [HI_W-1:0]   hi_snap;
  logic [CNT_W-1:0]  frames_val;
  logic [CNT_W-1:0]  cls_val [3];
  logic [CNT_W-1:0]  err_val [NERR];
  logic [CNT_W-1:0]  short_val;
  logic [CNT_W-1:0]  bkt_val [NBKT];
  logic [NBKT-1:0]   bkt_hit;
  logic [2:0]        cls_flag;
  logic              is_short;
  logic [RD_W-1:0]   rd_view [NSLOT];

  always_comb begin
    rd_sel = '0;
    if (rd_en) rd_sel[rd_addr] = 1'b1;
  end

  assign is_short = ev_valid && (ev_len < LEN_W'(SHORT_LEN));
  assign cls_flag = {ev_pause, ev_bcast, ev_mcast};

  rmon_ctr #(.W(OCT_W)) u_oct (
    .clk(clk), .rst(rst), .clr_all(clr_all), .rd_clr(rd_sel[A_OCT_LO]),
    .inc_en(ev_valid), .inc_amt(OCT_W'(ev_len)), .value(oct_val));

  always_ff @(posedge clk) begin
    if (rst || clr_all)
      hi_snap <= '0;
    else if (rd_sel[A_OCT_LO])
      hi_snap <= oct_val[OCT_W-1:RD_W];
  end

  rmon_ctr #(.W(CNT_W)) u_frames (
    .clk(clk), .rst(rst), .clr_all(clr_all), .rd_clr(rd_sel[A_FRAMES]),
    .inc_en(ev_valid), .inc_amt(CNT_W'(1)), .value(frames_val));

  for (genvar c = 0; c < 3; c++) begin : g_cls
    rmon_ctr #(.W(CNT_W)) u_c (
      .clk(clk), .rst(rst), .clr_all(clr_all), .rd_clr(rd_sel[A_MCAST + c]),
      .inc_en(ev_valid && cls_flag[c]), .inc_amt(CNT_W'(1)),
      .value(cls_val[c]));
  end

  for (genvar k = 0; k < NERR; k++) begin : g_err
    if (IS_RX || k == 0) begin : g_on
      rmon_ctr #(.W(CNT_W)) u_e (
        .clk(clk), .rst(rst), .clr_all(clr_all), .rd_clr(rd_sel[A_ERR0 + k]),
        .inc_en(ev_valid && ev_err[k]), .inc_amt(CNT_W'(1)),
        .value(err_val[k]));
    end else begin : g_off
      assign err_val[k] = '0;
    end
  end

  if (IS_RX) begin : g_short
    rmon_ctr #(.W(CNT_W)) u_s (
      .clk(clk), .rst(rst), .clr_all(clr_all), .rd_clr(rd_sel[A_SHORT]),
      .inc_en(is_short), .inc_amt(CNT_W'(1)), .value(short_val));
  end else begin : g_noshort
    assign short_val = '0;
  end

  rmon_bucket_sel #(.LEN_W(LEN_W), .NBKT(NBKT)) u_bsel (
    .valid(ev_valid), .len(ev_len), .hit(bkt_hit));

  for (genvar b = 0; b < NBKT; b++) begin : g_bkt
    rmon_ctr #(.W(CNT_W)) u_b (
      .clk(clk), .rst(rst), .clr_all(clr_all), .rd_clr(rd_sel[A_BKT0 + b]),
      .inc_en(bkt_hit[b]), .inc_amt(CNT_W'(1)), .value(bkt_val[b]));
  end

  always_comb begin
    for (int i = 0; i < NSLOT; i++) rd_view[i] = '0;
    rd_view[A_OCT_LO] = oct_val[RD_W-1:0];
    rd_view[A_OCT_HI] = RD_W'(hi_snap);
    rd_view[A_FRAMES] = RD_W'(frames_val);
    for (int c = 0; c < 3; c++)    rd_view[A_MCAST + c] = RD_W'(cls_val[c]);
    for (int k = 0; k < NERR; k++) rd_view[A_ERR0 + k]  = RD_W'(err_val[k]);
    rd_view[A_SHORT] = RD_W'(short_val);
    for (int b = 0; b < NBKT; b++) rd_view[A_BKT0 + b]  = RD_W'(bkt_val[b]);
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= rd_view[rd_addr];
  end
endmodule

// File: rtl/rmon_stats_bank_sva.sv
module rmon_stats_bank_sva
  import rmon_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int LEN_W = 16,
  parameter int RD_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              clr_all,
  input logic              ev_valid,
  input logic [LEN_W-1:0]  ev_len,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [RD_W-1:0]   rd_data,
  input logic [CNT_W-1:0]  frames_q,
  input logic [NBKT-1:0]   bkt_hit
);
  logic rd_frames;
  assign rd_frames = rd_en && (rd_addr == ADDR_W'(A_FRAMES));

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> frames_q == '0);

  assert_frame_inc_R2: assert property (@(posedge clk) disable iff (rst)
    ev_valid && !clr_all && !rd_frames |=> frames_q == $past(frames_q) + CNT_W'(1));

  assert_one_bin_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bkt_hit));

  assert_short_no_bin_R6: assert property (@(posedge clk) disable iff (rst)
    ev_valid && (ev_len < LEN_W'(64)) |-> bkt_hit == '0);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
    rd_frames && !clr_all && !ev_valid |=> frames_q == '0);

  assert_collide_restart_R8: assert property (@(posedge clk) disable iff (rst)
    rd_frames && !clr_all && ev_valid |=> frames_q == CNT_W'(1));

  assert_clear_all_R10: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> frames_q == '0);

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
    rd_en && (rd_addr >= ADDR_W'(NREG)) |=> rd_data == '0);
endmodule

bind rmon_stats_bank rmon_stats_bank_sva #(
  .CNT_W(CNT_W), .LEN_W(LEN_W), .RD_W(RD_W)
) u_sva (
  .clk(clk), .rst(rst), .clr_all(clr_all), .ev_valid(ev_valid),
  .ev_len(ev_len), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .frames_q(frames_val), .bkt_hit(bkt_hit));

// File: tb/rmon_stats_bank_test.sv
module rmon_stats_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr_all = 1'b0;
  logic        ev_valid = 1'b0;
  logic [15:0] ev_len = '0;
  logic        ev_mcast = 1'b0, ev_bcast = 1'b0, ev_pause = 1'b0;
  logic [4:0]  ev_err = '0;
  logic        rd_en = 1'b0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_rx, rd_tx;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  rmon_stats_bank #(.IS_RX(1'b1)) uut (
    .clk(clk), .rst(rst), .clr_all(clr_all), .ev_valid(ev_valid),
    .ev_len(ev_len), .ev_mcast(ev_mcast), .ev_bcast(ev_bcast),
    .ev_pause(ev_pause), .ev_err(ev_err), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_rx));

  rmon_stats_bank #(.IS_RX(1'b0)) uut_tx (
    .clk(clk), .rst(rst), .clr_all(clr_all), .ev_valid(ev_valid),
    .ev_len(ev_len), .ev_mcast(ev_mcast), .ev_bcast(ev_bcast),
    .ev_pause(ev_pause), .ev_err(ev_err), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_tx));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] rx, output logic [31:0] tx);
    @(negedge clk); rd_en = 1'b1; rd_addr = 5'(a);
    @(negedge clk); rd_en = 1'b0;
    rx = rd_rx; tx = rd_tx;
  endtask

  task automatic ev(input int len, input logic m, input logic b, input logic p,
                    input logic [4:0] e);
    @(negedge clk);
    ev_valid = 1'b1; ev_len = 16'(len); ev_mcast = m; ev_bcast = b;
    ev_pause = p; ev_err = e;
    @(negedge clk);
    ev_valid = 1'b0; ev_mcast = 1'b0; ev_bcast = 1'b0; ev_pause = 1'b0;
    ev_err = '0;
  endtask

  task automatic wipe();
    @(negedge clk); clr_all = 1'b1;
    @(negedge clk); clr_all = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] x, y;
    for (int a = 0; a < 19; a++) begin
      rd(a, x, y);
      chk("R1 rx reset", x, 0);
      chk("R1 tx reset", y, 0);
    end
  endtask

  task automatic t_basic();
    logic [31:0] x, y;
    wipe();
    ev(100, 1, 0, 0, 0);
    ev(64, 0, 1, 0, 0);
    ev(1600, 0, 0, 1, 0);
    rd(2, x, y);  chk("R2 frames", x, 3);  chk("R2 tx frames", y, 3);
    rd(0, x, y);  chk("R2 octets lo", x, 1764);
    rd(1, x, y);  chk("R2 octets hi", x, 0);
    rd(3, x, y);  chk("R3 mcast", x, 1);
    rd(4, x, y);  chk("R3 bcast", x, 1);
    rd(5, x, y);  chk("R3 pause", y, 1);
    rd(12, x, y); chk("R5 bin 64", x, 1);
    rd(13, x, y); chk("R5 bin 65-127", x, 1);
    rd(18, x, y); chk("R5 bin 1519+", x, 1);
    rd(2, x, y);  chk("R7 frames cleared by read", x, 0);
  endtask

  task automatic t_errors();
    logic [31:0] x, y;
    wipe();
    for (int k = 0; k < 5; k++) ev(200, 0, 0, 0, 5'(1 << k));
    ev(40, 0, 0, 0, 0);
    for (int k = 0; k < 5; k++) begin
      rd(6 + k, x, y);
      chk("R4 rx error category", x, 1);
      if (k == 0) chk("R12 tx general error", y, 1);
      else        chk("R12 tx ignores rx-only flag", y, 0);
    end
    rd(11, x, y); chk("R6 rx short", x, 1); chk("R12 tx no short", y, 0);
    rd(12, x, y); chk("R6 short frame not binned", x, 0);
    rd(14, x, y); chk("R5 bin 128-255", x, 5);
    rd(2, x, y);  chk("R2 frames incl short", x, 6);
  endtask

  task automatic t_edges();
    logic [31:0] x, y;
    int lens[11] = '{127, 128, 255, 256, 511, 512, 1023, 1024, 1518, 1519, 65};
    int exp[7] = '{0, 2, 2, 2, 2, 2, 1};
    wipe();
    foreach (lens[i]) ev(lens[i], 0, 0, 0, 0);
    for (int b = 0; b < 7; b++) begin
      rd(12 + b, x, y);
      chk("R5 bin edge", x, 32'(exp[b]));
    end
  endtask

  task automatic t_wide();
    logic [31:0] x, y;
    wipe();
    @(negedge clk); ev_valid = 1'b1; ev_len = 16'hFFFF;
    repeat (65540) @(negedge clk);
    ev_valid = 1'b0;
    // 65540 * 65535 = 2^32 + 196604
    rd(0, x, y); chk("R9 octets lo", x, 196604);
    rd(1, x, y); chk("R9 octets hi snapshot", x, 1);
    rd(0, x, y); chk("R7 octets cleared", x, 0);
    rd(1, x, y); chk("R9 hi snapshot refreshed", x, 0);
  endtask

  task automatic t_collide();
    logic [31:0] x, y;
    wipe();
    ev(70, 0, 0, 0, 0);
    ev(70, 0, 0, 0, 0);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 5'd2; ev_valid = 1'b1; ev_len = 16'd300;
    @(negedge clk);
    rd_en = 1'b0; ev_valid = 1'b0;
    chk("R8 read returns old value", rd_rx, 2);
    rd(2, x, y);  chk("R8 counter restarts at event", x, 1);
    rd(15, x, y); chk("R8 bin updated on collision", x, 1);
  endtask

  task automatic t_clear();
    logic [31:0] x, y;
    wipe();
    @(negedge clk); ev_valid = 1'b1; ev_len = 16'hFFFF;
    repeat (65540) @(negedge clk);
    ev_valid = 1'b0;
    rd(0, x, y);
    @(negedge clk); clr_all = 1'b1; ev_valid = 1'b1; ev_len = 16'd500;
    @(negedge clk); clr_all = 1'b0; ev_valid = 1'b0;
    rd(1, x, y);  chk("R10 snapshot cleared", x, 0);
    rd(2, x, y);  chk("R10 frames cleared, event dropped", x, 0);
    rd(15, x, y); chk("R10 bin cleared", x, 0);
    rd(18, x, y); chk("R10 top bin cleared", x, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] x, y;
    wipe();
    ev(100, 1, 1, 1, 5'h1F);
    rd(25, x, y); chk("R11 unmapped rx", x, 0); chk("R11 unmapped tx", y, 0);
    rd(31, x, y); chk("R11 unmapped top", x, 0);
    @(negedge clk); rd_en = 1'b1; rd_addr = 5'd3;
    @(posedge clk); #1;
    rd_en = 1'b0;
    chk("R11 data after one edge", rd_rx, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_errors();
    t_edges();
    t_collide();
    t_unmapped();
    t_wide();
    t_clear();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule